// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address stream for one read burst of a synchronous memory. A read command carries a start address, a burst length of four or eight, and an ordering choice. From the following cycle the block presents one address per clock: the start address first, then the remaining addresses of the aligned block of four or eight that holds it. The block can step through that block either by counting upward with wrap-around, or by XOR of the start offset with the beat number.

A synchronous clock enable pauses the block. At any rising edge where the enable is sampled low, the beat counter, the stored burst context and every output keep their values, and the command inputs are not looked at. Operation resumes on the first edge where the enable is sampled high, and a command presented at that edge takes effect.

The command decoder knows three cases. A high chip select deselects the decoder. With chip select low, all three strobes high form a no-operation. A read command starts a burst. Neither a deselect nor a no-operation starts a burst, and neither one disturbs a burst that is already running.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-low reset clears valid, done and the beat counter; valid and done stay low until a read command is accepted.
- R2: A read command (cs_n=0, ras_n=1, cas_n=0, mr_n=1) sampled with cke=1 starts a burst: from the next cycle valid=1 and addr_out equals the sampled start_addr.
- R3: Sequential order (interleave=0) with burst8=0: beat k has addr_out[1:0] = (start[1:0] + k) mod 4.
- R4: Sequential order with burst8=1: beat k has addr_out[2:0] = (start[2:0] + k) mod 8.
- R5: Interleaved order (interleave=1): beat k has the low field (2 bits when burst8=0, 3 bits when burst8=1) equal to the start's low field XOR k.
- R6: Address bits above the burst-length field keep the start value for the whole burst; with burst8=0 this includes bit 2.
- R7: valid is high for exactly 4 (burst8=0) or 8 (burst8=1) consecutive active cycles, and done is high only on the last of them.
- R8: At an edge where cke is sampled low, addr_out, valid, done and the beat position are held, and every other input, a read command included, is ignored.
- R9: At the first edge where cke is sampled high again, the burst continues from where it stopped, and a command present at that edge is accepted.
- R10: With cs_n=1 no burst starts, whatever the strobes are; a running burst continues.
- R11: A no-operation (cs_n=0, ras_n=cas_n=mr_n=1), or any other non-read command, starts no burst; a running burst continues.
- R12: A read command during a running burst ends that burst and starts the new one at the same edge, from beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| mr_n | input | 1 | Mode strobe, active low |
| start_addr | input | ADDR_W | Start column address, sampled with a read command |
| burst8 | input | 1 | Burst length: 1 selects eight beats, 0 selects four |
| interleave | input | 1 | Ordering: 1 selects XOR order, 0 selects wrapping count |
| addr_out | output | ADDR_W | Current burst address |
| valid | output | 1 | High while addr_out holds a burst beat |
| done | output | 1 | High on the last beat of a burst |

## Verification
Every start address of a 6-bit configuration is run with both burst lengths and both orderings. A start offset of zero makes both orderings give the same stream. Other offsets separate a wrapping count from an XOR and show whether bit 2 stays fixed in short bursts. The upper address bits vary across the sweep, which shows whether they pass through unchanged. Deselects that carry a read pattern, no-operations and other commands are mixed between beats, together with suspends in the middle of a burst, on its last beat and at a resume edge that carries a new read, so that a held burst can be told apart from a restarted or dropped one.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // Width of the widest reorderable address field (eight beats).
   localparam int BSQ_FIELD_W = 3;
   localparam int BSQ_BEAT_W  = BSQ_FIELD_W;

   typedef enum logic [1:0] {
      CMD_DESEL = 2'd0,
      CMD_NOP   = 2'd1,
      CMD_READ  = 2'd2,
      CMD_OTHER = 2'd3
   } bsq_cmd_e;

   typedef struct packed {
      logic len8;   // eight-beat burst
      logic ilv;    // XOR ordering
   } bsq_mode_t;

endpackage

// File: rtl/bseq_cmd_decode.sv
module bseq_cmd_decode
   import burst_seq_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic mr_n,
   output logic start
);

   bsq_cmd_e cmd;

   // A high chip select disables the decoder entirely.
   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         unique case ({ras_n, cas_n, mr_n})
            3'b111:  cmd = CMD_NOP;
            3'b101:  cmd = CMD_READ;
            default: cmd = CMD_OTHER;
         endcase
      end
   end

   assign start = (cmd == CMD_READ);

endmodule

// File: rtl/bseq_beat_ctrl.sv
module bseq_beat_ctrl
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 8
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adv,
   input  logic                  start,
   input  logic [ADDR_W-1:0]     start_addr,
   input  bsq_mode_t             mode_in,
   output logic                  active,
   output logic [BSQ_BEAT_W-1:0] beat,
   output logic [ADDR_W-1:0]     base,
   output bsq_mode_t             mode,
   output logic                  last
);

   localparam logic [BSQ_BEAT_W-1:0] LAST4 = BSQ_BEAT_W'(3);
   localparam logic [BSQ_BEAT_W-1:0] LAST8 = BSQ_BEAT_W'(7);

   logic [BSQ_BEAT_W-1:0] last_idx;

   assign last_idx = mode.len8 ? LAST8 : LAST4;
   assign last     = active && (beat == last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         beat   <= '0;
         base   <= '0;
         mode   <= '0;
      end else if (adv) begin
         if (start) begin
            active <= 1'b1;
            beat   <= '0;
            base   <= start_addr;
            mode   <= mode_in;
         end else if (last) begin
            active <= 1'b0;
            beat   <= '0;
         end else if (active) begin
            beat   <= beat + 1'b1;
         end
      end
   end

   // R1: reset clears the burst state
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!active && beat == '0));

   // R2: an accepted read loads the start address at beat 0
   p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && start) |=> (active && beat == '0 && base == $past(start_addr)));

   // R7: beats advance by one until the last
   p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && active && !last && !start) |=> (active && beat == $past(beat) + 1'b1));

   // R7: the burst closes after its last beat
   p_burst_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && last && !start) |=> !active);

   // R8: suspended edges change nothing
   p_hold_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(beat) && $stable(active) && $stable(base) && $stable(mode)));

   // R10: without a read, an idle sequencer stays idle
   p_idle_stay_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !active && !start) |=> !active);

endmodule

// File: rtl/bseq_addr_order.sv
module bseq_addr_order
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter bit INTERLEAVE_EN = 1'b1
)(
   input  logic [ADDR_W-1:0]     base,
   input  logic [BSQ_BEAT_W-1:0] beat,
   input  bsq_mode_t             mode,
   output logic [ADDR_W-1:0]     addr
);

   logic [BSQ_FIELD_W-1:0] seq_low;
   logic [BSQ_FIELD_W-1:0] low;

   // Wrapping count: the 3-bit sum wraps mod 8, its low 2 bits wrap mod 4.
   assign seq_low = base[BSQ_FIELD_W-1:0] + beat;

   generate
      if (INTERLEAVE_EN) begin : g_both
         logic [BSQ_FIELD_W-1:0] xor_low;
         assign xor_low = base[BSQ_FIELD_W-1:0] ^ beat;
         assign low     = mode.ilv ? xor_low : seq_low;
      end else begin : g_seq_only
         assign low = seq_low;
      end
   endgenerate

   // Per-bit source: field bits reorder, bit 2 only in long bursts, the rest pass.
   generate
      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
         if (i < BSQ_FIELD_W - 1) begin : g_short
            assign addr[i] = low[i];
         end else if (i == BSQ_FIELD_W - 1) begin : g_long
            assign addr[i] = mode.len8 ? low[i] : base[i];
         end else begin : g_pass
            assign addr[i] = base[i];
         end
      end
   endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter bit INTERLEAVE_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              mr_n,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              burst8,
   input  logic              interleave,
   output logic [ADDR_W-1:0] addr_out,
   output logic              valid,
   output logic              done
);

   generate
      if (ADDR_W < BSQ_FIELD_W) begin : g_bad_width
         $error("burst_addr_seq: ADDR_W must cover the 3-bit burst field");
      end
   endgenerate

   logic                  start;
   logic                  active;
   logic                  last;
   logic [BSQ_BEAT_W-1:0] beat;
   logic [ADDR_W-1:0]     base;
   bsq_mode_t             mode_in;
   bsq_mode_t             mode;

   assign mode_in.len8 = burst8;
   assign mode_in.ilv  = interleave;

   bseq_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .mr_n  (mr_n),
      .start (start)
   );

   bseq_beat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (cke),
      .start      (start),
      .start_addr (start_addr),
      .mode_in    (mode_in),
      .active     (active),
      .beat       (beat),
      .base       (base),
      .mode       (mode),
      .last       (last)
   );

   bseq_addr_order #(.ADDR_W(ADDR_W), .INTERLEAVE_EN(INTERLEAVE_EN)) u_order (
      .base (base),
      .beat (beat),
      .mode (mode),
      .addr (addr_out)
   );

   assign valid = active;
   assign done  = last;

   // R8: outputs are frozen across a suspended edge
   p_port_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(addr_out) && $stable(valid) && $stable(done)));

   // R2: a read accepted while enabled shows its start address next cycle
   p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !cs_n && ras_n && !cas_n && mr_n) |=> (valid && addr_out == $past(start_addr)));

   // R6: upper bits equal the start address on the first beat
   p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !cs_n && ras_n && !cas_n && mr_n) |=>
         (addr_out[ADDR_W-1:BSQ_FIELD_W] == $past(start_addr[ADDR_W-1:BSQ_FIELD_W])));

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n, cke, cs_n, ras_n, cas_n, mr_n, burst8, interleave;
   logic [AW-1:0] start_addr, addr_out;
   logic          valid, done;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .mr_n(mr_n), .start_addr(start_addr), .burst8(burst8),
      .interleave(interleave), .addr_out(addr_out), .valid(valid), .done(done)
   );

   function automatic int exp_addr(int s, int k, bit l8, bit il);
      int m   = l8 ? 7 : 3;
      int low = il ? (s ^ k) : (s + k);
      return ((s & ~m) | (low & m)) & ((1 << AW) - 1);
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // 0 read, 1 nop, 2 deselect carrying a read pattern, 3 other command
   task automatic cmd(int c, int a, bit l8, bit il);
      case (c)
         0:       {cs_n, ras_n, cas_n, mr_n} = 4'b0101;
         1:       {cs_n, ras_n, cas_n, mr_n} = 4'b0111;
         2:       {cs_n, ras_n, cas_n, mr_n} = 4'b1101;
         default: {cs_n, ras_n, cas_n, mr_n} = 4'b0011;
      endcase
      start_addr = AW'(a);
      burst8     = l8;
      interleave = il;
   endtask

   task automatic chk_beat(int s, int k, bit l8, bit il, string tag);
      int  e    = exp_addr(s, k, l8, il);
      bit  lst  = (k == (l8 ? 7 : 3));
      check(valid === 1'b1 && int'(addr_out) == e && done === lst,
            $sformatf("%s s=%0d k=%0d bl8=%0d ilv=%0d v=%0b d=%0b", tag, s, k, l8, il, valid, done),
            int'(addr_out), e);
   endtask

   task automatic chk_idle(string tag);
      check(valid === 1'b0 && done === 1'b0, tag, int'({valid, done}), 0);
   endtask

   // Watchdog: a hang counts as a failure and still reports.
   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cke   = 1'b1;
      cmd(1, 0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      chk_idle("R1 reset state");
      rst_n = 1'b1;

      // Idle: deselect with read pattern, nop, other command start nothing.
      cmd(2, 9, 1'b1, 1'b0);
      @(negedge clk); chk_idle("R10 deselect idle");
      cmd(1, 9, 1'b1, 1'b0);
      @(negedge clk); chk_idle("R11 nop idle");
      cmd(3, 9, 1'b1, 1'b0);
      @(negedge clk); chk_idle("R11 other idle");

      // Sweep: R2 R3 R4 R5 R6 R7, with R10 / R11 filler between beats.
      for (int s = 0; s < (1 << AW); s++) begin
         for (int l = 0; l < 2; l++) begin
            for (int il = 0; il < 2; il++) begin
               cmd(0, s, l[0], il[0]);
               for (int k = 0; k < (l ? 8 : 4); k++) begin
                  @(negedge clk);
                  chk_beat(s, k, l[0], il[0], "R2-R7 sweep");
                  cmd(((s % 2) == 1) ? 2 : 1, 63 - s, ~l[0], ~il[0]);
               end
               @(negedge clk);
               chk_idle("R7 burst ends");
            end
         end
      end

      // R8: suspend mid-burst with a read command present.
      cmd(0, 5, 1'b1, 1'b0);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); chk_beat(5, k, 1'b1, 1'b0, "R8 pre-suspend");
         cmd(1, 0, 1'b0, 1'b0);
      end
      cke = 1'b0;
      cmd(0, 40, 1'b0, 1'b1);
      for (int j = 0; j < 3; j++) begin
         @(negedge clk); chk_beat(5, 1, 1'b1, 1'b0, "R8 held during suspend");
      end
      cke = 1'b1;
      cmd(1, 0, 1'b0, 1'b0);
      for (int k = 2; k < 8; k++) begin
         @(negedge clk); chk_beat(5, k, 1'b1, 1'b0, "R9 resume continues");
      end
      @(negedge clk); chk_idle("R8 burst ends after resume");

      // R9: read presented on the resume edge is accepted.
      cmd(0, 10, 1'b0, 1'b1);
      @(negedge clk); chk_beat(10, 0, 1'b0, 1'b1, "R9 first beat");
      cke = 1'b0;
      cmd(1, 0, 1'b0, 1'b0);
      @(negedge clk); chk_beat(10, 0, 1'b0, 1'b1, "R8 hold beat 0");
      cke = 1'b1;
      cmd(0, 33, 1'b1, 1'b1);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); chk_beat(33, k, 1'b1, 1'b1, "R9 read on resume edge");
         cmd(1, 0, 1'b0, 1'b0);
      end
      @(negedge clk); chk_idle("R9 burst ends");

      // R8: suspend on the last beat keeps done high.
      cmd(0, 2, 1'b0, 1'b0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); chk_beat(2, k, 1'b0, 1'b0, "R8 short burst");
         cmd(1, 0, 1'b0, 1'b0);
      end
      cke = 1'b0;
      @(negedge clk); chk_beat(2, 3, 1'b0, 1'b0, "R8 done held");
      @(negedge clk); chk_beat(2, 3, 1'b0, 1'b0, "R8 done held again");
      cke = 1'b1;
      @(negedge clk); chk_idle("R8 ends after release");

      // R12: a new read restarts the burst on the same edge.
      cmd(0, 7, 1'b1, 1'b0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); chk_beat(7, k, 1'b1, 1'b0, "R12 first burst");
         cmd(1, 0, 1'b0, 1'b0);
      end
      cmd(0, 20, 1'b0, 1'b0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); chk_beat(20, k, 1'b0, 1'b0, "R12 restarted burst");
         cmd(1, 0, 1'b0, 1'b0);
      end
      @(negedge clk); chk_idle("R12 burst ends");

      // R1: reset in the middle of a burst.
      cmd(0, 3, 1'b1, 1'b1);
      @(negedge clk); chk_beat(3, 0, 1'b1, 1'b1, "R1 pre-reset beat");
      cmd(1, 0, 1'b0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk); chk_idle("R1 reset mid-burst");
      rst_n = 1'b1;
      @(negedge clk); chk_idle("R1 idle after reset");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule